// File: doc/BRIEF.md
# Receive Sampling Tap Sweep Controller

This block searches for the best receive sampling delay on a high-speed eMMC link. After a start pulse it walks a 6-bit tap value upward from zero through a fixed count of taps. Before judging a tap it raises a tap-update request toward the PHY and waits for the PHY to acknowledge that the update finished. Every tap gets this request round twice in a row, a workaround for a PHY whose receive path can miss a single update. If both rounds complete, an external tester is asked whether a tuning transfer at that tap succeeded.

While sweeping, the controller keeps the length of the current run of passing taps, the longest run seen so far and the tap at which that longest run ended. Once the last tap is judged, it programs the tap lying in the middle of the longest run. That final tap goes through the same two-round update, and then a one-cycle done pulse is raised. When no tap passed, the error flag is raised together with done and no final tap is programmed.

Top module: `tap_sweep_ctrl`

States of the sweep machine: IDLE (waiting for start), APPLY (launches an update sequence for the swept tap), APPLY_WAIT (waits for that sequence to finish or time out), TEST (tester handshake), SCORE (feeds the result to the streak tracker and advances the tap), DECIDE (checks whether any tap passed), CENTER (launches the update sequence for the centre tap), CENTER_WAIT (waits for it) and DONE (one-cycle completion). Transitions: IDLE to APPLY on start; APPLY to APPLY_WAIT always; APPLY_WAIT to TEST on a completed update, or to SCORE as a failure on timeout; TEST to SCORE on the tester acknowledge; SCORE back to APPLY, or to DECIDE after the last tap; DECIDE to DONE when the best run is empty, otherwise to CENTER; CENTER to CENTER_WAIT; CENTER_WAIT to DONE when the sequence finishes; DONE to IDLE. The update sequencer has the states IDLE, REQ (request held, timer running) and GAP (one idle cycle between rounds).

## Requirements
- R1: A sweep presents taps 0 to NUM_TAPS-1 (0 to 39 by default) in ascending order on tune_val_o; no value above 39 is ever requested while sweeping, although the field is 6 bits wide.
- R2: Each tap is applied by two request rounds: tune_req_o rises, stays high until tune_ack_i is seen, then drops for at least one cycle before the second round.
- R3: If tune_ack_i does not arrive within TMO_CYCLES cycles of a round (32 by default), the round is abandoned, the second round is skipped, the tester is not asked, and the tap counts as a failure.
- R4: A failing tap or a timed-out tap sets the current passing run to zero.
- R5: A passing tap grows the current run by one; the longest run and its end tap are replaced only when the current run becomes strictly longer.
- R6: After the last tap the programmed tap equals the end tap of the longest run minus half that run's length, rounded down, and appears on tap_o from the done cycle on.
- R7: Of two runs with equal maximum length, the earlier one decides the final tap.
- R8: If no tap passed, err_o is 1 from the done cycle on, no final update request is made, and tap_o keeps its former value.
- R9: A start pulse arriving while a sweep is in progress has no effect on that sweep.
- R10: done_o is high for exactly one cycle per sweep; err_o is cleared when a new sweep starts.
- R11: test_req_o is raised only after both update rounds of the current tap completed, and is held until test_ack_i, at which cycle test_pass_i is taken as the result (1 = pass).
- R12: After reset all request outputs, done_o, err_o and tap_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a sweep when idle |
| tune_val_o | output | 6 | Tap value offered to the PHY tuning field |
| tune_req_o | output | 1 | Tap-update request, held until acknowledged or timed out |
| tune_ack_i | input | 1 | PHY indication that the update bit cleared |
| test_req_o | output | 1 | Request to the tester to judge the current tap |
| test_ack_i | input | 1 | Tester response strobe |
| test_pass_i | input | 1 | Tester verdict, valid with test_ack_i, 1 = pass |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No passing tap was found in the last sweep |
| tap_o | output | 6 | Final centred tap |

## Verification
Every cycle the embedded properties check the tap bound during a sweep, that an acknowledged request drops, the round and timer bounds, that a failure clears the current run while a pass grows it by one, that the best run never shrinks within a sweep, that done is a single pulse, that the tester is only asked straight after a completed update, and that an empty result goes directly to done with tap_o unchanged. Only the bench's scenarios can show the arithmetic of the centre, the earlier-window rule for ties, the exact count of update rounds per tap including the timeout path, and that a start during a sweep leaves its result and request counts untouched.

// File: rtl/tap_sweep_pkg.sv
package tap_sweep_pkg;

    // Sweep-level states
    typedef enum logic [3:0] {
        S_IDLE,
        S_APPLY,
        S_APPLY_WAIT,
        S_TEST,
        S_SCORE,
        S_DECIDE,
        S_CENTER,
        S_CENTER_WAIT,
        S_DONE
    } sweep_state_e;

    // Update sequencer states
    typedef enum logic [1:0] {
        A_IDLE,
        A_REQ,
        A_GAP
    } apply_state_e;

endpackage

// File: rtl/tap_apply_seq.sv
module tap_apply_seq
    import tap_sweep_pkg::*;
#(
    parameter int ROUNDS     = 2,
    parameter int TMO_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic req_o,
    input  logic ack_i,
    output logic fin_o,
    output logic ok_o
);

    localparam int TW = $clog2(TMO_CYCLES + 1);
    localparam int RW = $clog2(ROUNDS + 1);
    localparam logic [TW-1:0] TMO_LAST   = TW'(TMO_CYCLES - 1);
    localparam logic [RW-1:0] ROUND_LAST = RW'(ROUNDS - 1);

    apply_state_e state_q, state_d;
    logic [TW-1:0] timer_q;
    logic [RW-1:0] round_q;
    logic          fin_q, ok_q;

    logic last_round, expired;
    assign last_round = (round_q == ROUND_LAST);
    assign expired    = (timer_q == TMO_LAST);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            A_IDLE: if (go_i) state_d = A_REQ;
            A_REQ: begin
                if (ack_i)        state_d = last_round ? A_IDLE : A_GAP;
                else if (expired) state_d = A_IDLE;
            end
            A_GAP:   state_d = A_REQ;
            default: state_d = A_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= A_IDLE;
        else        state_q <= state_d;
    end

    // timer, round counter and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            round_q <= '0;
            fin_q   <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            unique case (state_q)
                A_IDLE: begin
                    timer_q <= '0;
                    round_q <= '0;
                end
                A_REQ: begin
                    if (ack_i) begin
                        timer_q <= '0;
                        if (last_round) begin
                            fin_q <= 1'b1;
                            ok_q  <= 1'b1;
                        end else begin
                            round_q <= round_q + 1'b1;
                        end
                    end else if (expired) begin
                        fin_q <= 1'b1;
                        ok_q  <= 1'b0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                A_GAP:   timer_q <= '0;
                default: timer_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_o = (state_q == A_REQ);
        fin_o = fin_q;
        ok_o  = ok_q;
    end

    // R2: an acknowledged request is withdrawn on the next cycle
    p_ack_drops_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

    // R2: never more rounds than configured
    p_round_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        round_q < RW'(ROUNDS));

    // R3: the wait for an acknowledge is bounded
    p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q < TW'(TMO_CYCLES));

    // R3: an unanswered request at the limit ends the sequence as a failure
    p_timeout_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && expired) |=> (fin_o && !ok_o && !req_o));

endmodule

// File: rtl/streak_tracker.sv
module streak_tracker #(
    parameter int TAP_W = 6,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             upd_i,
    input  logic             pass_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [LEN_W-1:0] best_len_o,
    output logic [TAP_W-1:0] centre_o
);

    logic [LEN_W-1:0] cur_q, best_q;
    logic [TAP_W-1:0] end_q;
    logic [LEN_W-1:0] cur_inc;
    logic [LEN_W-1:0] half_len;

    assign cur_inc = cur_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (clr_i) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (upd_i) begin
            if (pass_i) begin
                cur_q <= cur_inc;
                if (cur_inc > best_q) begin
                    best_q <= cur_inc;
                    end_q  <= tap_i;
                end
            end else begin
                cur_q <= '0;
            end
        end
    end

    assign half_len   = best_q >> 1;
    assign best_len_o = best_q;
    assign centre_o   = end_q - TAP_W'(half_len);

    // R4: a failure empties the current run
    p_fail_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && !pass_i) |=> (cur_q == '0));

    // R5: a pass extends the current run by one
    p_pass_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && pass_i) |=> (cur_q == $past(cur_q) + 1'b1));

    // R5: the best run never shrinks during a sweep
    p_best_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (best_q >= $past(best_q)));

    // R7: a run only equal to the best leaves the recorded end alone
    p_tie_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && pass_i && (cur_inc <= best_q)) |=> $stable(end_q));

endmodule

// File: rtl/tap_sweep_ctrl.sv
module tap_sweep_ctrl
    import tap_sweep_pkg::*;
#(
    parameter int TAP_W      = 6,
    parameter int NUM_TAPS   = 40,
    parameter int ROUNDS     = 2,
    parameter int TMO_CYCLES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [TAP_W-1:0] tune_val_o,
    output logic             tune_req_o,
    input  logic             tune_ack_i,
    output logic             test_req_o,
    input  logic             test_ack_i,
    input  logic             test_pass_i,
    output logic             done_o,
    output logic             err_o,
    output logic [TAP_W-1:0] tap_o
);

    localparam int LEN_W = $clog2(NUM_TAPS + 1);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

    sweep_state_e state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] final_q;
    logic             pass_q;
    logic             err_q;

    logic             apply_go, apply_fin, apply_ok;
    logic             trk_clr, trk_upd;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] centre;
    logic             centring;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:        if (start_i) state_d = S_APPLY;
            S_APPLY:       state_d = S_APPLY_WAIT;
            S_APPLY_WAIT:  if (apply_fin) state_d = apply_ok ? S_TEST : S_SCORE;
            S_TEST:        if (test_ack_i) state_d = S_SCORE;
            S_SCORE:       state_d = (tap_q == LAST_TAP) ? S_DECIDE : S_APPLY;
            S_DECIDE:      state_d = (best_len == '0) ? S_DONE : S_CENTER;
            S_CENTER:      state_d = S_CENTER_WAIT;
            S_CENTER_WAIT: if (apply_fin) state_d = S_DONE;
            S_DONE:        state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // sweep datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q   <= '0;
            pass_q  <= 1'b0;
            err_q   <= 1'b0;
            final_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        tap_q <= '0;
                        err_q <= 1'b0;
                    end
                end
                S_APPLY_WAIT: if (apply_fin) pass_q <= 1'b0;
                S_TEST:       if (test_ack_i) pass_q <= test_pass_i;
                S_SCORE:      if (tap_q != LAST_TAP) tap_q <= tap_q + 1'b1;
                S_DECIDE:     if (best_len == '0) err_q <= 1'b1;
                S_CENTER_WAIT: begin
                    if (apply_fin) begin
                        if (apply_ok) final_q <= centre;
                        else          err_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        centring   = (state_q == S_CENTER) || (state_q == S_CENTER_WAIT);
        apply_go   = (state_q == S_APPLY) || (state_q == S_CENTER);
        test_req_o = (state_q == S_TEST);
        done_o     = (state_q == S_DONE);
        trk_upd    = (state_q == S_SCORE);
        trk_clr    = (state_q == S_IDLE) && start_i;
        tune_val_o = centring ? centre : tap_q;
        err_o      = err_q;
        tap_o      = final_q;
    end

    tap_apply_seq #(
        .ROUNDS    (ROUNDS),
        .TMO_CYCLES(TMO_CYCLES)
    ) u_apply (
        .clk  (clk),
        .rst_n(rst_n),
        .go_i (apply_go),
        .req_o(tune_req_o),
        .ack_i(tune_ack_i),
        .fin_o(apply_fin),
        .ok_o (apply_ok)
    );

    streak_tracker #(
        .TAP_W(TAP_W),
        .LEN_W(LEN_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (trk_clr),
        .upd_i     (trk_upd),
        .pass_i    (pass_q),
        .tap_i     (tap_q),
        .best_len_o(best_len),
        .centre_o  (centre)
    );

    // R1: the swept tap stays inside the allowed range
    p_tap_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !centring |-> (tap_q <= LAST_TAP));

    // R1: taps advance by exactly one per scoring step
    p_tap_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCORE && tap_q != LAST_TAP) |=> (tap_q == $past(tap_q) + 1'b1));

    // R10: done lasts a single cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: the tester is only asked right after a completed update
    p_test_after_apply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_req_o) |-> ($past(state_q) == S_APPLY_WAIT && $past(apply_ok)));

    // R8: an empty result ends the sweep without a final update
    p_empty_to_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECIDE && best_len == '0) |=> (done_o && err_o && !tune_req_o));

    // R8: the final tap only moves when the centre update completes
    p_final_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == S_CENTER_WAIT && apply_fin) |=> $stable(tap_o));

endmodule

// File: tb/tap_sweep_ctrl_test.sv
module tap_sweep_ctrl_test;

    localparam int NT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [5:0] tune_val_o;
    logic       tune_req_o;
    logic       tune_ack_i = 1'b0;
    logic       test_req_o;
    logic       test_ack_i = 1'b0;
    logic       test_pass_i = 1'b0;
    logic       done_o;
    logic       err_o;
    logic [5:0] tap_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bit [NT-1:0] pmap, hmap;
    int apply_cnt [64];
    int test_cnt;
    logic prev_treq = 1'b0, prev_qreq = 1'b0;
    int tdly = 0, qdly = 0;
    logic [5:0] exp_tap = '0;

    always #5 clk = ~clk;

    tap_sweep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tune_val_o(tune_val_o), .tune_req_o(tune_req_o), .tune_ack_i(tune_ack_i),
        .test_req_o(test_req_o), .test_ack_i(test_ack_i), .test_pass_i(test_pass_i),
        .done_o(done_o), .err_o(err_o), .tap_o(tap_o)
    );

    // PHY model: acknowledges update requests after a random delay unless the tap hangs
    always @(negedge clk) begin
        tune_ack_i <= 1'b0;
        if (tune_req_o && !tune_ack_i && !(tune_val_o < NT && hmap[tune_val_o])) begin
            if (tdly == 0) begin
                tune_ack_i <= 1'b1;
                tdly <= int'($urandom_range(0, 4));
            end else tdly <= tdly - 1;
        end
    end

    // tester model
    always @(negedge clk) begin
        test_ack_i <= 1'b0;
        if (test_req_o && !test_ack_i) begin
            if (qdly == 0) begin
                test_ack_i  <= 1'b1;
                test_pass_i <= (tune_val_o < NT) ? pmap[tune_val_o] : 1'b0;
                qdly <= int'($urandom_range(0, 3));
            end else qdly <= qdly - 1;
        end
    end

    // request monitors
    always @(negedge clk) begin
        if (tune_req_o && !prev_treq) apply_cnt[tune_val_o] = apply_cnt[tune_val_o] + 1;
        if (test_req_o && !prev_qreq) test_cnt = test_cnt + 1;
        prev_treq = tune_req_o;
        prev_qreq = test_req_o;
    end

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference: longest run with strict replacement, failing or hung taps break runs
    task automatic ref_best(output int blen, output int bend);
        int cur = 0;
        blen = 0;
        bend = 0;
        for (int i = 0; i < NT; i++) begin
            if (pmap[i] && !hmap[i]) begin
                cur++;
                if (cur > blen) begin
                    blen = cur;
                    bend = i;
                end
            end else cur = 0;
        end
    endtask

    task automatic run_case(input bit [NT-1:0] pm, input bit [NT-1:0] hm,
                            input bit mid_start, input string tag);
        int blen, bend, n, bad, bad_v, bad_a, bad_e, nhang;
        logic [5:0] cen;
        pmap = pm;
        hmap = hm;
        for (int v = 0; v < 64; v++) apply_cnt[v] = 0;
        test_cnt = 0;
        ref_best(blen, bend);
        cen = 6'(bend - blen / 2);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R10: err cleared once a sweep starts
        chk(err_o == 1'b0, {"R10 err cleared at start ", tag}, int'(err_o), 0);
        n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
            start_i = (mid_start && n == 150) ? 1'b1 : 1'b0;  // R9 stray start
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, {"R10 done reached ", tag}, int'(done_o), 1);
        if (blen == 0) begin
            chk(err_o == 1'b1, {"R8 err on empty sweep ", tag}, int'(err_o), 1);
        end else begin
            exp_tap = cen;
            chk(err_o == 1'b0, {"R6 no err with a window ", tag}, int'(err_o), 0);
        end
        chk(tap_o == exp_tap, {"R6 R7 R8 final tap ", tag}, int'(tap_o), int'(exp_tap));
        @(negedge clk);
        chk(done_o == 1'b0, {"R10 done single pulse ", tag}, int'(done_o), 0);
        // R1 R2 R3: update rounds per tap value
        bad = 0; bad_v = 0; bad_a = 0; bad_e = 0; nhang = 0;
        for (int v = 0; v < 64; v++) begin
            int e = 0;
            if (v < NT) begin
                e = hmap[v] ? 1 : 2;
                if (hmap[v]) nhang++;
            end
            if (blen > 0 && v == int'(cen)) e += 2;
            if (apply_cnt[v] != e && bad == 0) begin
                bad = 1; bad_v = v; bad_a = apply_cnt[v]; bad_e = e;
            end
        end
        chk(bad == 0, $sformatf("R1 R2 R3 update rounds at tap %0d %s", bad_v, tag), bad_a, bad_e);
        chk(test_cnt == NT - nhang, {"R11 R3 R9 tester requests ", tag}, test_cnt, NT - nhang);
    endtask

    function automatic bit [NT-1:0] span(input int lo, input int hi);
        bit [NT-1:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        pmap = '0;
        hmap = '0;
        for (int v = 0; v < 64; v++) apply_cnt[v] = 0;
        test_cnt = 0;
        repeat (3) @(negedge clk);
        // R12: reset values
        chk(tune_req_o == 0, "R12 tune_req_o in reset", int'(tune_req_o), 0);
        chk(test_req_o == 0, "R12 test_req_o in reset", int'(test_req_o), 0);
        chk(done_o == 0,     "R12 done_o in reset", int'(done_o), 0);
        chk(err_o == 0,      "R12 err_o in reset", int'(err_o), 0);
        chk(tap_o == 0,      "R12 tap_o in reset", int'(tap_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(span(0, 39), '0, 1'b0, "all pass R5");                       // centre 19
        run_case('0, '0, 1'b0, "none pass R8");                               // err, tap held
        run_case(span(5, 9) | span(20, 24), '0, 1'b0, "tie R7");              // centre 7
        run_case(span(39, 39), '0, 1'b0, "last tap only R6");                 // 39
        run_case(span(0, 0), '0, 1'b0, "first tap only R6");                  // 0
        run_case(span(0, 39), span(10, 10) | span(30, 30), 1'b0, "hang R3 R4"); // 20
        run_case(span(3, 5), '0, 1'b0, "odd window R6");                      // 4
        run_case(span(12, 27), '0, 1'b1, "mid start R9");                     // 19
        run_case(span(0, 9) | span(11, 39), span(2, 2), 1'b0, "fail split R4");
        for (int k = 0; k < 10; k++) begin
            bit [NT-1:0] pm, hm;
            pm = NT'({$urandom(), $urandom()}) | NT'({$urandom(), $urandom()});
            hm = NT'({$urandom(), $urandom()}) & NT'({$urandom(), $urandom()})
               & NT'({$urandom(), $urandom()});
            run_case(pm, hm, k[0], $sformatf("random %0d R5", k));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule